// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is one timer channel. A down counter runs from the bus clock through a selectable prescaler. The counter works with either 16 or 32 active bits. It runs in one of three modes:

- **Free-running:** the counter wraps through all ones.
- **Periodic:** the counter restarts from a stored reload value.
- **One-shot:** the counter stops at zero.

The counter raises a level interrupt each time it expires. Software reaches the timer over a simple synchronous word-addressed bus. A write is taken on the rising clock edge while select and write-enable are high. Read data is combinational from the address.

The stored reload value has two write paths. The immediate path also restarts the count on the next prescaled tick. The background path changes only what later reloads use. Both addresses read back the same stored value. In 16-bit mode the upper half of the count register is left as it was. Writing zero to the immediate path flags an interrupt at once. An interrupt clear write and the raw and masked status reads complete the interrupt handling.

Top module: `cdown_timer`

## Requirements
- R1: After reset, the reads are as follows: control reads 0x20, load reads 0, count reads 0xFFFFFFFF, raw status reads 0, and the irq output is 0.
- R2: The count changes only on prescaled ticks, and ticks happen only while the enable bit is set. While the timer is disabled the count holds its value.
- R3: In periodic mode, the count takes the stored reload value on the tick after the active count equals 1. With reload value N, one expiry follows the previous one after exactly N ticks.
- R4: The raw status bit is set on the tick where the active count expires from 1. With interrupts enabled, irq rises in the same cycle.
- R5: A write to address 1 (load) restarts the count with the written value on the next tick. A write to address 2 (background load) changes only the stored reload value and leaves the current count alone. Both addresses read the value written last.
- R6: Prescale code 00 gives a tick every clock, 01 every 16 clocks and 10 every 256 clocks. After the edge that sets the enable bit, the first tick lands on the 16th edge for code 01 and on the 256th edge for code 10.
- R7: In 16-bit mode only bits 15:0 decrement and expire, and bits 31:16 keep their contents. In free-running mode an expired counter wraps to all ones in its active width: 0xFFFF in the low half, or 0xFFFFFFFF.
- R8: In one-shot mode the count stops at zero. It raises no further interrupt until the load address is written again.
- R9: A write of any data to address 4 clears raw status. If an expiry happens in the same cycle, the set wins. Masked status at address 6 and the irq output both equal raw status ANDed with the interrupt enable.
- R10: Writing zero to the load address sets raw status on that clock edge, even while the timer is disabled.
- R11: The control register at address 0 has these fields:

  | Bit(s) | Field |
  |---|---|
  | 7 | enable |
  | 6 | periodic |
  | 5 | interrupt enable |
  | 3:2 | prescale |
  | 1 | 32-bit |
  | 0 | one-shot |

  Bit 4 and bits 31:8 read 0. Raw status is bit 0 of address 5 and address 7 reads 0. Writes to addresses 3, 5, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high with bus_sel |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Level interrupt, raw status gated by enable |

## Verification
Faults inside the counter, such as a wrong tick spacing, a lost pending load or a corrupted upper half, show on the count read within one prescaled tick. The bench therefore samples the count at exact edges that it works out from the enabling write. A raw-status fault shows on irq, and at address 5, on the clock edge after the expiry or the clear. Mode faults show on the tick after expiry: a wrong reload, no hold in one-shot mode, or a wrap to the wrong width.

// File: rtl/cdown_pkg.sv
package cdown_pkg;
  localparam int CNT_W  = 32;
  localparam int HALF_W = CNT_W / 2;
  localparam int PRE_W  = 8;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_LOAD   = 3'd1,
    A_BGLOAD = 3'd2,
    A_COUNT  = 3'd3,
    A_CLEAR  = 3'd4,
    A_RAW    = 3'd5,
    A_MASKED = 3'd6,
    A_NONE   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       ie;
    logic [1:0] pre;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{en: 1'b0, periodic: 1'b0, ie: 1'b1,
                                 pre: 2'b00, wide: 1'b0, oneshot: 1'b0};

  function automatic ctrl_t ctrl_from_word(input logic [7:0] w);
    ctrl_t c;
    c.en       = w[7];
    c.periodic = w[6];
    c.ie       = w[5];
    c.pre      = w[3:2];
    c.wide     = w[1];
    c.oneshot  = w[0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
    return {{(DATA_W-8){1'b0}}, c.en, c.periodic, c.ie, 1'b0, c.pre, c.wide, c.oneshot};
  endfunction

  // divisor minus one for a prescale code; code 11 behaves like 10
  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] code);
    case (code)
      2'b00:   return '0;
      2'b01:   return PRE_W'(15);
      default: return '1;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] active_part(input logic [CNT_W-1:0] v, input logic wide);
    return wide ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  function automatic logic [CNT_W-1:0] merge_active(input logic [CNT_W-1:0] old_v,
                                                    input logic [CNT_W-1:0] new_v,
                                                    input logic wide);
    return wide ? new_v : {old_v[CNT_W-1:HALF_W], new_v[HALF_W-1:0]};
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] reload,
                                                  input ctrl_t c);
    logic [CNT_W-1:0] act;
    act = active_part(cur, c.wide);
    if (c.oneshot) begin
      if (act == '0) return cur;
      return merge_active(cur, act - 1'b1, c.wide);
    end
    if (c.periodic && (act == CNT_W'(1) || act == '0)) return reload;
    if (act == '0) return merge_active(cur, '1, c.wide);
    return merge_active(cur, act - 1'b1, c.wide);
  endfunction
endpackage

// File: rtl/cdown_prescale.sv
module cdown_prescale
  import cdown_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] pre,
  output logic       tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] lim;

  assign lim  = pre_limit(pre);
  assign tick = en && (div_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)      div_q <= '0;
    else if (!en)    div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // R6: a divided tick is never followed by another tick on the next clock
  a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim != '0) |=> (!tick || pre_limit(pre) == '0));
endmodule

// File: rtl/cdown_counter.sv
module cdown_counter
  import cdown_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ctrl_t            ctl,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             zero_evt
);
  logic pending_q;

  assign zero_evt = tick && !pending_q && (active_part(count, ctl.wide) == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '1;
      pending_q <= 1'b0;
    end else begin
      if (tick) begin
        if (pending_q) count <= reload;
        else           count <= next_count(count, reload, ctl);
      end
      pending_q <= load_wr || (pending_q && !tick);
    end
  end

  a_r8_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.oneshot && !pending_q && active_part(count, ctl.wide) == '0) |=> $stable(count));

  a_r7_upper_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pending_q && !ctl.wide) |=> $stable(count[CNT_W-1:HALF_W]));

  a_r3_reload_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && ctl.periodic && !ctl.oneshot) |=> (count == $past(reload)));
endmodule

// File: rtl/cdown_regs.sv
module cdown_regs
  import cdown_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              zero_evt,
  output ctrl_t             ctl,
  output logic [CNT_W-1:0]  reload,
  output logic              load_wr,
  output logic              raw,
  output logic              irq,
  output logic [DATA_W-1:0] bus_rdata
);
  logic wr, bg_wr, clr_wr, ctl_wr, raw_set;

  assign wr      = bus_sel && bus_we;
  assign ctl_wr  = wr && (bus_addr == A_CTRL);
  assign load_wr = wr && (bus_addr == A_LOAD);
  assign bg_wr   = wr && (bus_addr == A_BGLOAD);
  assign clr_wr  = wr && (bus_addr == A_CLEAR);
  assign raw_set = zero_evt || (load_wr && bus_wdata == '0);
  assign irq     = raw && ctl.ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= CTRL_RST;
      reload <= '0;
      raw    <= 1'b0;
    end else begin
      if (ctl_wr)           ctl    <= ctrl_from_word(bus_wdata[7:0]);
      if (load_wr || bg_wr) reload <= bus_wdata;
      if (raw_set)          raw    <= 1'b1;
      else if (clr_wr)      raw    <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_e'(bus_addr))
      A_CTRL:           bus_rdata = ctrl_to_word(ctl);
      A_LOAD, A_BGLOAD: bus_rdata = reload;
      A_COUNT:          bus_rdata = count;
      A_RAW:            bus_rdata = {{(DATA_W-1){1'b0}}, raw};
      A_MASKED:         bus_rdata = {{(DATA_W-1){1'b0}}, irq};
      default:          bus_rdata = '0;
    endcase
  end

  a_r4_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> raw);

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !raw_set) |=> !raw);
endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
  import cdown_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctrl_t            ctl;
  logic             tick, zero_evt, load_wr, raw;
  logic [CNT_W-1:0] reload, count;

  cdown_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .en(ctl.en), .pre(ctl.pre), .tick(tick)
  );

  cdown_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl(ctl), .load_wr(load_wr),
    .reload(reload), .count(count), .zero_evt(zero_evt)
  );

  cdown_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count),
    .zero_evt(zero_evt), .ctl(ctl), .reload(reload), .load_wr(load_wr),
    .raw(raw), .irq(irq), .bus_rdata(bus_rdata)
  );

  a_r2_disabled_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |=> $stable(count));

  a_r10_zero_load_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == A_LOAD && bus_wdata == '0) |=> raw);
endmodule

// File: tb/cdown_timer_bench.sv
module cdown_timer_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  cdown_timer u_cdown_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    expect_reg("R1 ctrl", 3'd0, 32'h20);
    expect_reg("R1 load", 3'd1, 32'h0);
    expect_reg("R1 count", 3'd3, 32'hFFFF_FFFF);
    expect_reg("R1 raw", 3'd5, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_half_width();
    wr(3'd1, 32'h0001_0003);
    expect_reg("R5 load waits for tick", 3'd3, 32'hFFFF_FFFF);
    wr(3'd0, 32'hA2);
    expect_reg("R2 no tick on enabling edge", 3'd3, 32'hFFFF_FFFF);
    idle(1);
    expect_reg("R5 immediate load", 3'd3, 32'h0001_0003);
    wr(3'd0, 32'h22);
    expect_reg("R2 last tick", 3'd3, 32'h0001_0002);
    idle(3);
    expect_reg("R2 frozen while disabled", 3'd3, 32'h0001_0002);
    wr(3'd0, 32'hA0);
    expect_reg("R2 frozen on enable edge", 3'd3, 32'h0001_0002);
    idle(1);
    expect_reg("R7 low half decrements", 3'd3, 32'h0001_0001);
    expect_reg("R4 raw before expiry", 3'd5, 32'h0);
    idle(1);
    expect_reg("R7 upper kept", 3'd3, 32'h0001_0000);
    expect_reg("R4 raw at expiry", 3'd5, 32'h1);
    chk("R4 irq at expiry", {31'b0, irq}, 32'h1);
    idle(1);
    expect_reg("R7 16-bit wrap", 3'd3, 32'h0001_FFFF);
    wr(3'd0, 32'h20);
    wr(3'd4, 32'h0);
    expect_reg("R9 clear", 3'd5, 32'h0);
  endtask

  task automatic t_periodic();
    wr(3'd1, 32'd3);
    wr(3'd0, 32'hE2);
    idle(1);
    expect_reg("R5 periodic start", 3'd3, 32'd3);
    wr(3'd2, 32'd7);
    expect_reg("R5 bg load keeps count", 3'd3, 32'd2);
    expect_reg("R5 load addr shows bg", 3'd1, 32'd7);
    expect_reg("R5 bg addr readback", 3'd2, 32'd7);
    idle(1);
    expect_reg("R3 count 1", 3'd3, 32'd1);
    idle(1);
    expect_reg("R3 reload", 3'd3, 32'd7);
    expect_reg("R4 periodic raw", 3'd5, 32'h1);
    wr(3'd4, 32'h5A);
    expect_reg("R9 clear any data", 3'd5, 32'h0);
    expect_reg("R3 after clear", 3'd3, 32'd6);
    idle(5);
    expect_reg("R3 before next expiry", 3'd3, 32'd1);
    wr(3'd4, 32'h0);
    expect_reg("R9 set wins over clear", 3'd5, 32'h1);
    expect_reg("R3 interval of 7", 3'd3, 32'd7);
    wr(3'd0, 32'h20);
    wr(3'd4, 32'h0);
  endtask

  task automatic t_oneshot_div16();
    logic [31:0] c0;
    rd(3'd3, c0);
    wr(3'd1, 32'd2);
    wr(3'd0, 32'hA7);
    idle(15);
    expect_reg("R6 no tick before 16th edge", 3'd3, c0);
    idle(1);
    expect_reg("R6 first tick at 16th edge", 3'd3, 32'd2);
    idle(16);
    expect_reg("R6 second tick", 3'd3, 32'd1);
    expect_reg("R8 raw not yet", 3'd5, 32'h0);
    idle(16);
    expect_reg("R8 reaches zero", 3'd3, 32'd0);
    expect_reg("R8 raw at zero", 3'd5, 32'h1);
    wr(3'd4, 32'h0);
    idle(40);
    expect_reg("R8 holds at zero", 3'd3, 32'd0);
    expect_reg("R8 no second interrupt", 3'd5, 32'h0);
    wr(3'd0, 32'h20);
  endtask

  task automatic t_div256();
    wr(3'd1, 32'd10);
    wr(3'd0, 32'h88);
    idle(255);
    expect_reg("R6 no tick before 256th edge", 3'd3, 32'd0);
    idle(1);
    expect_reg("R6 tick at 256th edge", 3'd3, 32'd10);
    wr(3'd0, 32'h20);
  endtask

  task automatic t_zero_and_mask();
    wr(3'd4, 32'h0);
    wr(3'd1, 32'h0);
    expect_reg("R10 zero load raw", 3'd5, 32'h1);
    chk("R10 zero load irq", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h00);
    chk("R9 masked irq", {31'b0, irq}, 32'h0);
    expect_reg("R9 masked status", 3'd6, 32'h0);
    expect_reg("R9 raw unmasked", 3'd5, 32'h1);
    wr(3'd0, 32'h20);
    expect_reg("R9 masked status on", 3'd6, 32'h1);
  endtask

  task automatic t_ignored();
    logic [31:0] c;
    wr(3'd0, 32'hFFFF_FF10);
    expect_reg("R11 reserved bits zero", 3'd0, 32'h0);
    wr(3'd0, 32'h6F);
    expect_reg("R11 field positions", 3'd0, 32'h6F);
    wr(3'd0, 32'h20);
    rd(3'd3, c);
    wr(3'd3, 32'h1234);
    expect_reg("R11 count write ignored", 3'd3, c);
    wr(3'd5, 32'h0);
    wr(3'd6, 32'h0);
    wr(3'd7, 32'h0);
    expect_reg("R11 status write ignored", 3'd5, 32'h1);
    expect_reg("R11 spare addr reads zero", 3'd7, 32'h0);
  endtask

  task automatic t_wrap32();
    wr(3'd4, 32'h0);
    wr(3'd1, 32'd1);
    wr(3'd0, 32'h82);
    idle(1);
    expect_reg("R7 loaded 1", 3'd3, 32'd1);
    idle(1);
    expect_reg("R4 32-bit expiry raw", 3'd5, 32'h1);
    idle(1);
    expect_reg("R7 32-bit wrap", 3'd3, 32'hFFFF_FFFF);
    wr(3'd0, 32'h20);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_half_width();
    t_periodic();
    t_oneshot_div16();
    t_div256();
    t_zero_and_mask();
    t_ignored();
    t_wrap32();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule